// File: doc/BRIEF.md
# Store/Recall Power Sequencer

This block decides when a fast volatile array is copied to its nonvolatile twin (a store) and when it is copied back (a recall). It watches a power-good flag, decoded software commands, and a shared active-low busy line that other logic may pull low to request a store. It runs a recall each time power returns. On a power failure it runs a store if automatic store is armed and the array has changed. It also serves store and recall commands from software.

The block does not move data. It gives a one-cycle start pulse and a direction to a copy engine, then waits for that engine's done pulse. A timeout counter limits the wait. While a copy is running, while power is low, or while the busy line is held low from outside, the array is locked and writes are refused. After each copy, writes stay refused until the host has deselected the array for at least one cycle.

Top module: `nvs_seq`

## Requirements
- R1: After reset the array is disabled (`sram_en`=0), the busy line is released, and no copy starts while `pwr_good` is low. The first cycle with `pwr_good` high starts a recall: `cp_start`=1 with `cp_dir`=0 (0 means recall, 1 means store). A recall also starts each time power returns after a brownout.
- R2: A power failure in the ready state, with automatic store armed and the array changed, starts a store (`cp_dir`=1). If power is still low when the copy ends, the block goes to the brownout state and the array stays disabled.
- R3: A power failure with automatic store disarmed goes to the brownout state with no copy. The array stays disabled until power returns.
- R4: While `busy_in` is low, `sram_en` is 0 in the same cycle. An external low on `busy_in` while the array is changed starts a store on the next clock edge.
- R5: `wr_allow` is 0 whenever `pwr_good` is low or the array is disabled. After every copy it also stays 0 until one ready cycle has passed with `ce`=0.
- R6: `busy_drive_low` is 1 from the start pulse until the copy ends, and 0 in every other state. `sram_en` is 1 only in the ready state.
- R7: A software store command starts a store (`cp_dir`=1) only when the array has been written since the last completed copy (`SKIP_CLEAN`=1); otherwise it does nothing. A software recall command always starts a recall.
- R8: `autostore_on` resets to `AS_INIT` (1). The arm command sets it and the disarm command clears it. A recall does not change it.
- R9: A power failure takes priority over a software command in the same cycle.
- R10: If no done pulse arrives within `TIMEOUT_CYC` cycles of the start, the copy ends and `timeout_err` becomes set and stays set.
- R11: A write attempt (`ce`=1 and `we`=1) made while writes are refused sets `wr_dropped`, which stays set.
- R12: `cp_start` is a single-cycle pulse, given only on the edge that enters a copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good | input | 1 | Supply is good (0 = power failing) |
| ce | input | 1 | Host array select |
| we | input | 1 | Host write strobe |
| busy_in | input | 1 | Sensed level of the shared busy line, active low |
| sw_store | input | 1 | Decoded software store command (pulse) |
| sw_recall | input | 1 | Decoded software recall command (pulse) |
| sw_as_on | input | 1 | Decoded command to arm automatic store |
| sw_as_off | input | 1 | Decoded command to disarm automatic store |
| cp_done | input | 1 | Copy engine has finished |
| sram_en | output | 1 | Array access enabled |
| wr_allow | output | 1 | Current write is let through |
| busy_drive_low | output | 1 | Pull the busy line low |
| cp_start | output | 1 | Start pulse to the copy engine |
| cp_dir | output | 1 | Copy direction: 1 store, 0 recall |
| autostore_on | output | 1 | Automatic store is armed |
| timeout_err | output | 1 | Sticky copy timeout flag |
| wr_dropped | output | 1 | Sticky refused-write flag |

## Verification
Two situations are hard to reach from the ports. The first is a copy that never finishes. The bench withholds the done pulse after a recall command and counts the cycles to the exact edge where the busy line is released. The second is a power failure that arrives together with a software recall while the array is changed. The bench first writes through a clean select cycle to make the array changed. It then drops power and raises the command in the same cycle, and expects a store, not a recall.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

    typedef enum logic [2:0] {
        PH_RESET  = 3'd0,
        PH_RECALL = 3'd1,
        PH_READY  = 3'd2,
        PH_STORE  = 3'd3,
        PH_BROWN  = 3'd4
    } phase_t;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_STORE  = 2'd1,
        ACT_RECALL = 2'd2,
        ACT_BROWN  = 2'd3
    } act_t;

    typedef struct packed {
        act_t act;
        logic arm;
        logic disarm;
    } pick_t;

    localparam logic DIR_RECALL = 1'b0;
    localparam logic DIR_STORE  = 1'b1;

    function automatic logic in_copy(phase_t p);
        return (p == PH_RECALL) || (p == PH_STORE);
    endfunction

endpackage

// File: rtl/nvs_pick.sv
module nvs_pick
    import nvs_pkg::*;
#(
    parameter bit SKIP_CLEAN = 1'b1
) (
    input  logic  pwr_fail,
    input  logic  hw_low,
    input  logic  sw_store,
    input  logic  sw_recall,
    input  logic  sw_as_on,
    input  logic  sw_as_off,
    input  logic  as_en,
    input  logic  dirty,
    output pick_t pick
);

    logic need_store;
    logic any_copy_cmd;

    assign need_store   = dirty || !SKIP_CLEAN;
    assign any_copy_cmd = pwr_fail || hw_low || sw_store || sw_recall;

    always_comb begin
        pick = '{act: ACT_NONE, arm: 1'b0, disarm: 1'b0};
        if (pwr_fail) begin
            pick.act = (as_en && need_store) ? ACT_STORE : ACT_BROWN;
        end else if (hw_low) begin
            pick.act = need_store ? ACT_STORE : ACT_NONE;
        end else if (sw_store) begin
            pick.act = need_store ? ACT_STORE : ACT_NONE;
        end else if (sw_recall) begin
            pick.act = ACT_RECALL;
        end
        pick.arm    = !any_copy_cmd && sw_as_on;
        pick.disarm = !any_copy_cmd && !sw_as_on && sw_as_off;
    end

endmodule

// File: rtl/nvs_watch.sv
module nvs_watch #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);

    localparam int CW = $clog2(LIMIT) + 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    assign expired = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    p_cnt_cap_r10: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

endmodule

// File: rtl/nvs_seq.sv
module nvs_seq
    import nvs_pkg::*;
#(
    parameter int TIMEOUT_CYC = 64,
    parameter bit SKIP_CLEAN  = 1'b1,
    parameter bit AS_INIT     = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_good,
    input  logic ce,
    input  logic we,
    input  logic busy_in,
    input  logic sw_store,
    input  logic sw_recall,
    input  logic sw_as_on,
    input  logic sw_as_off,
    input  logic cp_done,
    output logic sram_en,
    output logic wr_allow,
    output logic busy_drive_low,
    output logic cp_start,
    output logic cp_dir,
    output logic autostore_on,
    output logic timeout_err,
    output logic wr_dropped
);

    phase_t phase;
    logic   dirty;
    logic   wr_lock;
    logic   expired;
    logic   op_end;
    logic   wr_ok;
    pick_t  pick;

    nvs_pick #(.SKIP_CLEAN(SKIP_CLEAN)) u_pick (
        .pwr_fail  (!pwr_good),
        .hw_low    (!busy_in),
        .sw_store  (sw_store),
        .sw_recall (sw_recall),
        .sw_as_on  (sw_as_on),
        .sw_as_off (sw_as_off),
        .as_en     (autostore_on),
        .dirty     (dirty),
        .pick      (pick)
    );

    nvs_watch #(.LIMIT(TIMEOUT_CYC)) u_watch (
        .clk     (clk),
        .rst     (rst),
        .run     (in_copy(phase)),
        .expired (expired)
    );

    assign busy_drive_low = in_copy(phase);
    assign sram_en        = (phase == PH_READY) && busy_in;
    assign wr_ok          = sram_en && pwr_good && !wr_lock;
    assign wr_allow       = ce && we && wr_ok;
    assign op_end         = cp_done || expired;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase        <= PH_RESET;
            autostore_on <= AS_INIT;
            dirty        <= 1'b0;
            wr_lock      <= 1'b1;
            cp_start     <= 1'b0;
            cp_dir       <= DIR_RECALL;
            timeout_err  <= 1'b0;
            wr_dropped   <= 1'b0;
        end else begin
            cp_start <= 1'b0;
            if (wr_allow) dirty <= 1'b1;
            if (ce && we && !wr_ok) wr_dropped <= 1'b1;
            if (phase == PH_READY && !ce) wr_lock <= 1'b0;

            case (phase)
                PH_RESET: begin
                    if (pwr_good) begin
                        phase    <= PH_RECALL;
                        cp_start <= 1'b1;
                        cp_dir   <= DIR_RECALL;
                    end
                end
                PH_RECALL, PH_STORE: begin
                    if (op_end) begin
                        wr_lock <= 1'b1;
                        if (cp_done) dirty <= 1'b0;
                        else         timeout_err <= 1'b1;
                        if (phase == PH_STORE && !pwr_good) phase <= PH_BROWN;
                        else                                 phase <= PH_READY;
                    end
                end
                PH_READY: begin
                    if (pick.arm)    autostore_on <= 1'b1;
                    if (pick.disarm) autostore_on <= 1'b0;
                    case (pick.act)
                        ACT_STORE: begin
                            phase    <= PH_STORE;
                            cp_start <= 1'b1;
                            cp_dir   <= DIR_STORE;
                        end
                        ACT_RECALL: begin
                            phase    <= PH_RECALL;
                            cp_start <= 1'b1;
                            cp_dir   <= DIR_RECALL;
                        end
                        ACT_BROWN: phase <= PH_BROWN;
                        default: ;
                    endcase
                end
                PH_BROWN: begin
                    wr_lock <= 1'b1;
                    if (pwr_good) phase <= PH_RESET;
                end
                default: phase <= PH_RESET;
            endcase
        end
    end

    p_ext_low_off_r4: assert property (@(posedge clk) disable iff (rst)
        !busy_in |-> !sram_en);

    p_lowv_nowr_r5: assert property (@(posedge clk) disable iff (rst)
        !pwr_good |-> !wr_allow);

    p_copy_nowr_r6: assert property (@(posedge clk) disable iff (rst)
        busy_drive_low |-> !wr_allow);

    p_start_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        cp_start |=> !cp_start);

    p_start_busy_r12: assert property (@(posedge clk) disable iff (rst)
        cp_start |-> busy_drive_low);

    p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        timeout_err |=> timeout_err);

    p_drop_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        wr_dropped |=> wr_dropped);

endmodule

// File: tb/nvs_seq_test.sv
module nvs_seq_test;

    localparam int LIM = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwr_good = 1'b0;
    logic ce = 1'b0, we = 1'b0, ext_low = 1'b0;
    logic sw_store = 1'b0, sw_recall = 1'b0, sw_as_on = 1'b0, sw_as_off = 1'b0;
    logic cp_done = 1'b0;
    logic busy_in;
    logic sram_en, wr_allow, busy_drive_low, cp_start, cp_dir;
    logic autostore_on, timeout_err, wr_dropped;

    int total = 0;
    int fails = 0;

    always #2 clk = ~clk;

    assign busy_in = ~(busy_drive_low | ext_low);

    nvs_seq #(.TIMEOUT_CYC(LIM), .SKIP_CLEAN(1'b1), .AS_INIT(1'b1)) uut (
        .clk(clk), .rst(rst), .pwr_good(pwr_good), .ce(ce), .we(we),
        .busy_in(busy_in), .sw_store(sw_store), .sw_recall(sw_recall),
        .sw_as_on(sw_as_on), .sw_as_off(sw_as_off), .cp_done(cp_done),
        .sram_en(sram_en), .wr_allow(wr_allow), .busy_drive_low(busy_drive_low),
        .cp_start(cp_start), .cp_dir(cp_dir), .autostore_on(autostore_on),
        .timeout_err(timeout_err), .wr_dropped(wr_dropped)
    );

    // {ce, we, ext_low, expected wr_allow, expected sram_en}
    localparam logic [4:0] VEC [0:5] = '{
        5'b00001, 5'b10001, 5'b11100, 5'b01100, 5'b11011, 5'b01001
    };

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic done_pulse();
        cp_done = 1'b1;
        step();
        cp_done = 1'b0;
    endtask

    task automatic make_dirty();
        ce = 1'b0; we = 1'b0;
        step();
        ce = 1'b1; we = 1'b1;
        #1 chk("R5", "wr_allow after deselect", wr_allow, 1'b1);
        step();
        ce = 1'b0; we = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        chk("R1", "sram_en after reset", sram_en, 1'b0);
        chk("R1", "busy after reset", busy_drive_low, 1'b0);
        chk("R8", "autostore reset value", autostore_on, 1'b1);
        step();
        chk("R1", "no start while power low", cp_start, 1'b0);

        pwr_good = 1'b1;
        step();
        chk("R1", "recall start", cp_start, 1'b1);
        chk("R1", "recall dir", cp_dir, 1'b0);
        chk("R6", "busy during recall", busy_drive_low, 1'b1);
        step();
        chk("R12", "start is one cycle", cp_start, 1'b0);
        done_pulse();
        chk("R6", "busy released", busy_drive_low, 1'b0);
        chk("R6", "sram_en in ready", sram_en, 1'b1);

        ce = 1'b1; we = 1'b1;
        #1 chk("R5", "write locked after copy", wr_allow, 1'b0);
        step();
        ce = 1'b0; we = 1'b0;

        for (int i = 0; i < 6; i++) begin
            ce = VEC[i][4]; we = VEC[i][3]; ext_low = VEC[i][2];
            #1;
            chk("R5", $sformatf("vec %0d wr_allow", i), wr_allow, VEC[i][1]);
            chk("R4", $sformatf("vec %0d sram_en", i), sram_en, VEC[i][0]);
            step();
        end
        ce = 1'b0; we = 1'b0; ext_low = 1'b0;
        chk("R11", "dropped write flag", wr_dropped, 1'b1);

        sw_store = 1'b1;
        step();
        sw_store = 1'b0;
        chk("R7", "sw store start", cp_start, 1'b1);
        chk("R7", "sw store dir", cp_dir, 1'b1);
        done_pulse();
        sw_store = 1'b1;
        step();
        sw_store = 1'b0;
        chk("R7", "clean store skipped start", cp_start, 1'b0);
        chk("R7", "clean store skipped busy", busy_drive_low, 1'b0);

        sw_recall = 1'b1;
        step();
        sw_recall = 1'b0;
        chk("R7", "sw recall start", cp_start, 1'b1);
        chk("R7", "sw recall dir", cp_dir, 1'b0);
        done_pulse();

        sw_recall = 1'b1;
        step();
        sw_recall = 1'b0;
        chk("R10", "busy at copy start", busy_drive_low, 1'b1);
        repeat (LIM - 1) step();
        chk("R10", "busy on last timeout cycle", busy_drive_low, 1'b1);
        chk("R10", "no error before expiry", timeout_err, 1'b0);
        step();
        chk("R10", "copy ended on timeout", busy_drive_low, 1'b0);
        chk("R10", "timeout error set", timeout_err, 1'b1);

        sw_as_off = 1'b1;
        step();
        sw_as_off = 1'b0;
        chk("R8", "disarm", autostore_on, 1'b0);
        make_dirty();
        pwr_good = 1'b0; ce = 1'b1; we = 1'b1;
        #1 chk("R5", "write blocked at low power", wr_allow, 1'b0);
        step();
        ce = 1'b0; we = 1'b0;
        chk("R3", "no store when disarmed", cp_start, 1'b0);
        chk("R3", "busy stays released", busy_drive_low, 1'b0);
        chk("R3", "sram off in brownout", sram_en, 1'b0);
        step();
        chk("R3", "sram still off", sram_en, 1'b0);
        pwr_good = 1'b1;
        step();
        step();
        chk("R1", "recall after brownout", cp_start, 1'b1);
        chk("R1", "recall dir after brownout", cp_dir, 1'b0);
        done_pulse();
        chk("R8", "flag kept over recall", autostore_on, 1'b0);

        sw_as_on = 1'b1;
        step();
        sw_as_on = 1'b0;
        chk("R8", "arm", autostore_on, 1'b1);
        make_dirty();
        pwr_good = 1'b0; sw_recall = 1'b1;
        step();
        sw_recall = 1'b0;
        chk("R9", "power fail wins start", cp_start, 1'b1);
        chk("R9", "power fail wins dir", cp_dir, 1'b1);
        done_pulse();
        chk("R2", "brownout after store busy", busy_drive_low, 1'b0);
        chk("R2", "brownout after store sram", sram_en, 1'b0);
        pwr_good = 1'b1;
        step();
        step();
        chk("R1", "recall after store brownout", cp_start, 1'b1);
        done_pulse();

        make_dirty();
        ext_low = 1'b1;
        #1 chk("R4", "external low disables sram", sram_en, 1'b0);
        step();
        chk("R4", "hardware store start", cp_start, 1'b1);
        chk("R4", "hardware store dir", cp_dir, 1'b1);
        ext_low = 1'b0;
        done_pulse();
        chk("R6", "sram back after store", sram_en, 1'b1);
        chk("R10", "timeout flag sticky", timeout_err, 1'b1);
        chk("R11", "dropped flag sticky", wr_dropped, 1'b1);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule